// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control unit of a small single-issue processor with 16-bit instructions. It decodes the instruction word that the datapath presents each cycle. From that word it drives these controls:

- the next-program-counter select;
- the data-memory request and write enable;
- the register-file source select and write enable;
- the ALU function code.

Most instructions finish in one cycle. Three kinds take longer:

- A load holds the program counter for one fixed extra cycle. That cycle lets the synchronous data memory return its word.
- A transfer to or from the IO device holds the program counter for as long as the device takes to answer.
- A halt instruction freezes the processor until reset.

The IO device is reached through two one-cycle request/acknowledge pairs, one for each direction. The datapath, the memories and the register file lie outside the block. While the controller holds the program counter, the datapath keeps presenting the same instruction word. The controller therefore re-reads that word in every wait cycle.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: An opcode (instruction bits 15:12) from 0x0 to 0x7 is an ALU operation. In that cycle `rf_we` is 1, `rf_src` is 00 (ALU result), `alu_op` equals opcode bits 2:0 and `pc_sel` is 00 (advance). In every other cycle `alu_op` is 0.
- R2: Opcodes 0xC, 0xD and 0xE do nothing. All requests and write enables stay 0, and `pc_sel` is 00.
- R3: A load (opcode 0x8) takes two cycles. In the first cycle `dmem_req` is 1, `dmem_we` is 0, `rf_we` is 0 and `pc_sel` is 01 (hold). In the second cycle `rf_src` is 01 (memory), `rf_we` is 1, `dmem_req` is 0 and `pc_sel` is 00. The cycle after that decodes normally.
- R4: A store (opcode 0x9) asserts `dmem_req` and `dmem_we` together for one cycle, with `pc_sel` 00 and no wait.
- R5: An output transfer (opcode 0xB) asserts `out_req` for exactly one cycle, with `pc_sel` 01. The controller then holds (`pc_sel` 01, no request) until a cycle with `out_ack`=1. That cycle gives `pc_sel` 00. `in_ack` has no effect during this wait.
- R6: An input transfer (opcode 0xA) asserts `in_req` for exactly one cycle, with `pc_sel` 01. The controller then holds until a cycle with `in_ack`=1. In that cycle `rf_src` is 10 (IO data), `rf_we` is 1 and `pc_sel` is 00. `out_ack` has no effect during this wait.
- R7: An acknowledge in the cycle right after the request ends the wait in that cycle. Acknowledges that arrive while no transfer is waiting change no output.
- R8: The halt opcode 0xF gives `pc_sel` 01 from its own cycle onward. The controller then keeps `pc_sel` 01 with all requests and write enables at 0, whatever the instruction and acknowledges, until reset.
- R9: Reset (`rst_n` low) acts at once, without waiting for a clock. While it is low, `pc_sel` is 10 (reset PC) and every other output is 0. After release the first instruction is decoded from the run state.
- R10: At most one of `dmem_req`, `in_req` and `out_req` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst | input | 16 | Current instruction word from the datapath |
| pc_sel | output | 2 | Next-PC select: 00 advance, 01 hold, 10 reset PC |
| dmem_req | output | 1 | Data-memory access request |
| dmem_we | output | 1 | Data-memory write enable |
| rf_src | output | 2 | Register-file source: 00 ALU, 01 memory, 10 IO input |
| rf_we | output | 1 | Register-file write enable |
| alu_op | output | 3 | ALU function code |
| in_ack | input | 1 | IO device has placed input data (one cycle) |
| out_ack | input | 1 | IO device has taken output data (one cycle) |
| in_req | output | 1 | Request for one input word (one cycle) |
| out_req | output | 1 | Request to send one output word (one cycle) |

## Verification
Three things can fall in the same cycle and must be told apart:

- the end of an IO wait;
- the arrival of the acknowledge for the other direction;
- an acknowledge arriving while the controller runs normally.

The bench raises both `in_ack` and `out_ack` together in the first wait cycle of each transfer direction. It also raises stray acknowledges beside ALU, store and load instructions. A behavioural model, stepped cycle by cycle, judges each case. Only the matching acknowledge may release `pc_sel` and, for input, raise `rf_we` with source 10. Stray acknowledges must leave every output as the instruction alone dictates.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

   // Smallest opcode field that holds the fixed non-ALU sub-codes.
   localparam int unsigned MIN_OPC_W = 4;

   // Sub-codes carried in the low three opcode bits when the opcode MSB is set.
   localparam logic [2:0] SUB_LOAD  = 3'd0;
   localparam logic [2:0] SUB_STORE = 3'd1;
   localparam logic [2:0] SUB_IN    = 3'd2;
   localparam logic [2:0] SUB_OUT   = 3'd3;
   localparam logic [2:0] SUB_HALT  = 3'd7;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_LD_WAIT,
      ST_OUT_WAIT,
      ST_IN_WAIT,
      ST_HALT
   } seq_state_e;

   typedef enum logic [2:0] {
      IC_ALU,
      IC_LOAD,
      IC_STORE,
      IC_IN,
      IC_OUT,
      IC_HALT,
      IC_NOP
   } inst_class_e;

   typedef enum logic [1:0] {
      PC_NEXT = 2'b00,
      PC_HOLD = 2'b01,
      PC_ZERO = 2'b10
   } pc_sel_e;

   typedef enum logic [1:0] {
      RS_ALU = 2'b00,
      RS_MEM = 2'b01,
      RS_IO  = 2'b10
   } rf_src_e;

endpackage

// File: rtl/cpu_seq_decode.sv
module cpu_seq_decode
   import cpu_seq_pkg::*;
#(
   parameter int unsigned INST_W = 16,
   parameter int unsigned OPC_W  = 4
) (
   input  logic [INST_W-1:0] inst,
   output inst_class_e       cls,
   output logic [OPC_W-2:0]  alu_fn
);
   localparam int unsigned OPC_LSB = INST_W - OPC_W;
   localparam int unsigned FN_W    = OPC_W - 1;

   logic [OPC_W-1:0] opc;
   logic             ext_ok;
   logic             unused_operand;

   assign opc            = inst[INST_W-1:OPC_LSB];
   assign unused_operand = ^inst[OPC_LSB-1:0];

   // Wider opcode fields reserve the bits above the sub-code; they must be zero.
   generate
      if (OPC_W == MIN_OPC_W) begin : g_narrow_opc
         assign ext_ok = 1'b1;
      end else begin : g_wide_opc
         assign ext_ok = (opc[OPC_W-2:3] == '0);
      end
   endgenerate

   always_comb begin
      cls    = IC_NOP;
      alu_fn = '0;
      if (!opc[OPC_W-1]) begin
         cls    = IC_ALU;
         alu_fn = opc[FN_W-1:0];
      end else if (ext_ok) begin
         case (opc[2:0])
            SUB_LOAD:  cls = IC_LOAD;
            SUB_STORE: cls = IC_STORE;
            SUB_IN:    cls = IC_IN;
            SUB_OUT:   cls = IC_OUT;
            SUB_HALT:  cls = IC_HALT;
            default:   cls = IC_NOP;
         endcase
      end
   end

endmodule

// File: rtl/cpu_seq_fsm.sv
module cpu_seq_fsm
   import cpu_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  inst_class_e cls,
   input  logic        in_ack,
   input  logic        out_ack,
   output seq_state_e  state
);
   seq_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      case (state)
         ST_RUN: begin
            case (cls)
               IC_LOAD: state_nxt = ST_LD_WAIT;
               IC_IN:   state_nxt = ST_IN_WAIT;
               IC_OUT:  state_nxt = ST_OUT_WAIT;
               IC_HALT: state_nxt = ST_HALT;
               default: state_nxt = ST_RUN;
            endcase
         end
         ST_LD_WAIT:  state_nxt = ST_RUN;
         ST_OUT_WAIT: if (out_ack) state_nxt = ST_RUN;
         ST_IN_WAIT:  if (in_ack)  state_nxt = ST_RUN;
         ST_HALT:     state_nxt = ST_HALT;
         default:     state_nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= state_nxt;
   end

endmodule

// File: rtl/cpu_seq_outgen.sv
module cpu_seq_outgen
   import cpu_seq_pkg::*;
#(
   parameter int unsigned OPC_W = 4
) (
   input  logic             rst_n,
   input  seq_state_e       state,
   input  inst_class_e      cls,
   input  logic [OPC_W-2:0] alu_fn,
   input  logic             in_ack,
   input  logic             out_ack,
   output pc_sel_e          pc_sel,
   output logic             dmem_req,
   output logic             dmem_we,
   output rf_src_e          rf_src,
   output logic             rf_we,
   output logic [OPC_W-2:0] alu_op,
   output logic             in_req,
   output logic             out_req
);
   always_comb begin
      pc_sel   = PC_NEXT;
      dmem_req = 1'b0;
      dmem_we  = 1'b0;
      rf_src   = RS_ALU;
      rf_we    = 1'b0;
      alu_op   = '0;
      in_req   = 1'b0;
      out_req  = 1'b0;
      if (!rst_n) begin
         pc_sel = PC_ZERO;
      end else begin
         case (state)
            ST_RUN: begin
               case (cls)
                  IC_ALU: begin
                     rf_we  = 1'b1;
                     alu_op = alu_fn;
                  end
                  IC_LOAD: begin
                     dmem_req = 1'b1;
                     pc_sel   = PC_HOLD;
                  end
                  IC_STORE: begin
                     dmem_req = 1'b1;
                     dmem_we  = 1'b1;
                  end
                  IC_IN: begin
                     in_req = 1'b1;
                     pc_sel = PC_HOLD;
                  end
                  IC_OUT: begin
                     out_req = 1'b1;
                     pc_sel  = PC_HOLD;
                  end
                  IC_HALT: pc_sel = PC_HOLD;
                  default: pc_sel = PC_NEXT;
               endcase
            end
            ST_LD_WAIT: begin
               rf_src = RS_MEM;
               rf_we  = 1'b1;
            end
            ST_OUT_WAIT: begin
               if (!out_ack) pc_sel = PC_HOLD;
            end
            ST_IN_WAIT: begin
               if (in_ack) begin
                  rf_src = RS_IO;
                  rf_we  = 1'b1;
               end else begin
                  pc_sel = PC_HOLD;
               end
            end
            default: pc_sel = PC_HOLD;
         endcase
      end
   end

endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
   import cpu_seq_pkg::*;
#(
   parameter int unsigned INST_W = 16,
   parameter int unsigned OPC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INST_W-1:0] inst,
   output logic [1:0]        pc_sel,
   output logic              dmem_req,
   output logic              dmem_we,
   output logic [1:0]        rf_src,
   output logic              rf_we,
   output logic [OPC_W-2:0]  alu_op,
   input  logic              in_ack,
   input  logic              out_ack,
   output logic              in_req,
   output logic              out_req
);
   generate
      if (OPC_W < MIN_OPC_W) begin : g_bad_opc_w
         $error("cpu_seq_ctrl: OPC_W must be at least 4");
      end
      if (OPC_W >= INST_W) begin : g_bad_inst_w
         $error("cpu_seq_ctrl: INST_W must exceed OPC_W");
      end
   endgenerate

   inst_class_e      cls;
   logic [OPC_W-2:0] alu_fn;
   seq_state_e       state;
   pc_sel_e          pc_sel_w;
   rf_src_e          rf_src_w;

   cpu_seq_decode #(.INST_W(INST_W), .OPC_W(OPC_W)) u_dec (
      .inst   (inst),
      .cls    (cls),
      .alu_fn (alu_fn)
   );

   cpu_seq_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cls     (cls),
      .in_ack  (in_ack),
      .out_ack (out_ack),
      .state   (state)
   );

   cpu_seq_outgen #(.OPC_W(OPC_W)) u_out (
      .rst_n    (rst_n),
      .state    (state),
      .cls      (cls),
      .alu_fn   (alu_fn),
      .in_ack   (in_ack),
      .out_ack  (out_ack),
      .pc_sel   (pc_sel_w),
      .dmem_req (dmem_req),
      .dmem_we  (dmem_we),
      .rf_src   (rf_src_w),
      .rf_we    (rf_we),
      .alu_op   (alu_op),
      .in_req   (in_req),
      .out_req  (out_req)
   );

   assign pc_sel = pc_sel_w;
   assign rf_src = rf_src_w;

endmodule

// File: rtl/cpu_seq_ctrl_chk.sv
module cpu_seq_ctrl_chk
   import cpu_seq_pkg::*;
#(
   parameter int unsigned OPC_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input seq_state_e       state,
   input logic [1:0]       pc_sel,
   input logic             dmem_req,
   input logic             dmem_we,
   input logic [1:0]       rf_src,
   input logic             rf_we,
   input logic [OPC_W-2:0] alu_op,
   input logic             in_ack,
   input logic             out_ack,
   input logic             in_req,
   input logic             out_req
);
   AST_ALU_CODE_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op != '0) |-> (rf_we && rf_src == RS_ALU && state == ST_RUN)); // R1

   AST_LOAD_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (dmem_req && !dmem_we) |-> (pc_sel == PC_HOLD && !rf_we)); // R3

   AST_LOAD_SECOND_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (dmem_req && !dmem_we) |=> (rf_we && rf_src == RS_MEM && pc_sel == PC_NEXT && !dmem_req)); // R3

   AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> (dmem_req && pc_sel == PC_NEXT)); // R4

   AST_OUT_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_req |=> (!out_req && state == ST_OUT_WAIT)); // R5

   AST_OUT_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OUT_WAIT && !out_ack) |-> (pc_sel == PC_HOLD && !rf_we)); // R5

   AST_IN_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      in_req |=> (!in_req && state == ST_IN_WAIT)); // R6

   AST_IN_FILL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_src == RS_IO) |-> (state == ST_IN_WAIT && in_ack)); // R6

   AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT) |=> (state == ST_HALT)); // R8

   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT) |-> (pc_sel == PC_HOLD && !rf_we && !dmem_req && !in_req && !out_req)); // R8

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dmem_req, in_req, out_req}) <= 1); // R10

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_SELECT: assert (pc_sel == PC_ZERO && !rf_we && !dmem_req && !in_req && !out_req); // R9
      end
   end

endmodule

bind cpu_seq_ctrl cpu_seq_ctrl_chk #(.OPC_W(OPC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state),
   .pc_sel   (pc_sel),
   .dmem_req (dmem_req),
   .dmem_we  (dmem_we),
   .rf_src   (rf_src),
   .rf_we    (rf_we),
   .alu_op   (alu_op),
   .in_ack   (in_ack),
   .out_ack  (out_ack),
   .in_req   (in_req),
   .out_req  (out_req)
);

// File: tb/cpu_seq_ctrl_test.sv
module cpu_seq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] inst = 16'h0000;
   logic        in_ack = 1'b0;
   logic        out_ack = 1'b0;
   logic [1:0]  pc_sel;
   logic        dmem_req, dmem_we;
   logic [1:0]  rf_src;
   logic        rf_we;
   logic [2:0]  alu_op;
   logic        in_req, out_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   bit summary_done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   cpu_seq_ctrl uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .inst     (inst),
      .pc_sel   (pc_sel),
      .dmem_req (dmem_req),
      .dmem_we  (dmem_we),
      .rf_src   (rf_src),
      .rf_we    (rf_we),
      .alu_op   (alu_op),
      .in_ack   (in_ack),
      .out_ack  (out_ack),
      .in_req   (in_req),
      .out_req  (out_req)
   );

   // Behavioural model: 0 run, 1 load wait, 2 out wait, 3 in wait, 4 halted
   int m_st   = 0;
   int m_nxt  = 0;
   int m_wait = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st   = 0;
         m_wait = 0;
      end else begin
         m_wait = (m_nxt == m_st) ? m_wait + 1 : 0;
         m_st   = m_nxt;
      end
   end

   always @(negedge clk) begin : model_chk
      logic [3:0]  op;
      logic [1:0]  e_pc, e_src;
      logic        e_dreq, e_dwe, e_we, e_ireq, e_oreq;
      logic [2:0]  e_alu;
      logic [11:0] exp_v, act_v;
      string       tag;
      op = inst[15:12];
      e_pc = 2'b00; e_src = 2'b00; e_dreq = 0; e_dwe = 0; e_we = 0;
      e_ireq = 0; e_oreq = 0; e_alu = 3'd0; tag = "R1";
      m_nxt = m_st;
      if (!rst_n) begin
         e_pc = 2'b10; tag = "R9"; m_nxt = 0;
      end else begin
         case (m_st)
            0: begin
               if (op < 4'h8) begin
                  e_we = 1; e_alu = op[2:0]; tag = "R1";
               end else if (op == 4'h8) begin
                  e_dreq = 1; e_pc = 2'b01; m_nxt = 1; tag = "R3";
               end else if (op == 4'h9) begin
                  e_dreq = 1; e_dwe = 1; tag = "R4";
               end else if (op == 4'hA) begin
                  e_ireq = 1; e_pc = 2'b01; m_nxt = 3; tag = "R6";
               end else if (op == 4'hB) begin
                  e_oreq = 1; e_pc = 2'b01; m_nxt = 2; tag = "R5";
               end else if (op == 4'hF) begin
                  e_pc = 2'b01; m_nxt = 4; tag = "R8";
               end else begin
                  tag = "R2";
               end
               if (in_ack || out_ack) tag = "R7";
            end
            1: begin
               e_src = 2'b01; e_we = 1; m_nxt = 0; tag = "R3";
            end
            2: begin
               if (out_ack) m_nxt = 0;
               else e_pc = 2'b01;
               tag = (m_wait == 0 && out_ack) ? "R7" : "R5";
            end
            3: begin
               if (in_ack) begin
                  e_src = 2'b10; e_we = 1; m_nxt = 0;
               end else begin
                  e_pc = 2'b01;
               end
               tag = (m_wait == 0 && in_ack) ? "R7" : "R6";
            end
            default: begin
               e_pc = 2'b01; tag = "R8";
            end
         endcase
      end
      exp_v = {e_pc, e_dreq, e_dwe, e_src, e_we, e_alu, e_ireq, e_oreq};
      act_v = {pc_sel, dmem_req, dmem_we, rf_src, rf_we, alu_op, in_req, out_req};
      n_tests++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s: op=%h outputs got %h expected %h", tag, op, act_v, exp_v);
      end
      // R10: never two requests at once
      n_tests++;
      if (32'($countones({dmem_req, in_req, out_req})) > 1) begin
         n_fail++;
         $display("FAIL R10: requests got %b expected at most one set",
                  {dmem_req, in_req, out_req});
      end
   end

   task automatic cyc(input logic [3:0] op, input logic ia, input logic oa);
      inst    = {op, 12'h5A3};
      in_ack  = ia;
      out_ack = oa;
      @(posedge clk);
      #2;
   endtask

   task automatic print_summary();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: every ALU code, R2: unused codes
      for (int k = 0; k < 8; k++) cyc(4'(k), 1'b0, 1'b0);
      cyc(4'hC, 0, 0); cyc(4'hD, 0, 0); cyc(4'hE, 0, 0);
      // R4 store, R3 load (instruction held during wait), back to back
      cyc(4'h9, 0, 0);
      cyc(4'h8, 0, 0); cyc(4'h8, 0, 0);
      cyc(4'h8, 0, 0); cyc(4'h8, 0, 0);
      cyc(4'h9, 0, 0);
      // R5 output with delayed ack and a stray in_ack during the wait
      cyc(4'hB, 0, 0); cyc(4'hB, 1, 0); cyc(4'hB, 0, 0); cyc(4'hB, 0, 1);
      // R7 output acknowledged in the first wait cycle, together with in_ack
      cyc(4'hB, 0, 0); cyc(4'hB, 1, 1);
      // R6 input with delayed ack and a stray out_ack during the wait
      cyc(4'hA, 0, 0); cyc(4'hA, 0, 1); cyc(4'hA, 0, 0); cyc(4'hA, 1, 0);
      // R7 input acknowledged at once, both acks together
      cyc(4'hA, 0, 0); cyc(4'hA, 1, 1);
      // R7 stray acks while running
      cyc(4'h1, 1, 0); cyc(4'h9, 0, 1); cyc(4'h8, 1, 1); cyc(4'h8, 0, 0);
      cyc(4'hC, 1, 1);
      // R6 long wait
      cyc(4'hA, 0, 0);
      repeat (50) cyc(4'hA, 0, 0);
      cyc(4'hA, 1, 0);
      // R9 asynchronous reset in the middle of an output wait
      cyc(4'hB, 0, 0); cyc(4'hB, 0, 0);
      #5 rst_n = 1'b0;
      #1;
      n_tests++;
      if (pc_sel !== 2'b10 || out_req !== 1'b0) begin
         n_fail++;
         $display("FAIL R9: async reset pc_sel got %b expected 10", pc_sel);
      end
      @(posedge clk); #2;
      rst_n = 1'b1;
      cyc(4'h2, 0, 0); cyc(4'h6, 0, 0);
      // R8 halt ignores everything until reset
      cyc(4'hF, 0, 0); cyc(4'h3, 1, 1);
      cyc(4'hA, 0, 0); cyc(4'hB, 1, 0); cyc(4'h8, 0, 1); cyc(4'h9, 0, 0);
      rst_n = 1'b0;
      cyc(4'h3, 0, 0);
      rst_n = 1'b1;
      cyc(4'h3, 0, 0); cyc(4'hE, 0, 0);
      done = 1'b1;
      print_summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         print_summary();
         $finish;
      end
   end

endmodule